// File: doc/BRIEF.md
# Single-Accumulator Processor

This block is a small one-address processor. It holds one 16-bit accumulator, a 12-bit program counter and a word-addressed memory inside the block. Program and data share that memory. Each instruction names one memory word. The processor can load that word into the accumulator, add it to the accumulator, subtract it from the accumulator, or store the accumulator into it. It can also branch to the address, either always or only when the zero flag is set. A halt instruction stops execution.

Before a run, the memory is filled through a load port, which accepts writes only while reset is asserted. When reset is released, the processor fetches from address 0x000 and runs until it meets a halt. After that, the results can be read at any time through a combinational peek port.

Memory holds `MEM_WORDS` words, a power of two. Only the low bits of each address that this depth needs select a word.

Top module: `accum_core`

## Requirements
- R1: An instruction word carries the operation code in bits 15:12 and a direct word address in bits 11:0.
- R2: While reset is low, the accumulator reads 0x0000, the program counter reads 0x000, `halted` is low and the zero flag is clear.
- R3: Operation code 0010 copies the addressed word into the accumulator.
- R4: Operation code 0001 adds the addressed word to the accumulator, and the sum wraps modulo 2^16.
- R5: Operation code 0100 subtracts the addressed word from the accumulator, and the difference wraps modulo 2^16.
- R6: Operation code 0011 writes the accumulator into the addressed word.
- R7: Only load, add and subtract update the zero flag, which is set exactly when their 16-bit result is 0x0000. Store, both branches and no-ops leave the flag unchanged.
- R8: Operation code 0101 loads the program counter from the address field when the zero flag is set. Otherwise execution continues with the next word.
- R9: Operation code 0110 always loads the program counter from the address field, and the target may lie before or after the branch.
- R10: Operation code 1111 raises `halted`. From then on there is no fetch, and the program counter, accumulator and memory stay unchanged until reset is asserted again.
- R11: The operation codes 0000 and 0111 through 1110 change neither the accumulator, the zero flag nor memory. Execution simply moves on to the next word.
- R12: Every instruction takes exactly three clock cycles: fetch, decode and execute. A run of N executed instructions, the last of which is a halt, raises `halted` on the 3N-th rising edge after reset is released.
- R13: A write on the load port takes effect only while `rst_n` is low. With `rst_n` high it is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the processor state (memory is not cleared) |
| load_en | input | 1 | Load-port write strobe, honoured only during reset |
| load_addr | input | 12 | Load-port word address |
| load_data | input | 16 | Load-port write data |
| peek_addr | input | 12 | Word address for the combinational peek port |
| peek_data | output | 16 | Content of the word at `peek_addr` |
| acc_out | output | 16 | Current accumulator value |
| pc_out | output | 12 | Current program counter |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The fetch edge advances the program counter, and the execute edge, the third of each instruction, updates the accumulator, the zero flag, memory and any branch target. For a program of N executed instructions, the bench therefore expects `halted` low after 3N-1 edges and high after exactly 3N. It counts edges from the release of reset to confirm this cycle total, both for straight-line code and for a loop. The bench drives and samples on falling edges, so every register on a path has settled half a cycle before it is read. It reads memory results only through the peek port, after `halted` has risen, or while reset is held.

// File: rtl/accum_pkg.sv
`timescale 1ns/1ps
// Package accum_pkg
// Shared constants and types for the accumulator processor.
// Assumes the instruction format is fixed: a 4-bit operation code above a 12-bit address.
package accum_pkg;
    localparam int WORD_W = 16;
    localparam int OP_W   = 4;
    localparam int ADDR_W = WORD_W - OP_W;

    localparam logic [OP_W-1:0] OP_ADD   = 4'b0001;
    localparam logic [OP_W-1:0] OP_LOAD  = 4'b0010;
    localparam logic [OP_W-1:0] OP_STORE = 4'b0011;
    localparam logic [OP_W-1:0] OP_SUB   = 4'b0100;
    localparam logic [OP_W-1:0] OP_BRZ   = 4'b0101;
    localparam logic [OP_W-1:0] OP_BR    = 4'b0110;
    localparam logic [OP_W-1:0] OP_HALT  = 4'b1111;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_HALT   = 2'd3
    } phase_e;
endpackage

// File: rtl/accum_mem.sv
`timescale 1ns/1ps
// Module accum_mem
// Unified program and data store: one synchronous write port and two combinational read ports.
// Assumes WORDS is a power of two; callers pass already truncated word indices.
module accum_mem #(
    parameter int WORDS  = 1024,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] cells [WORDS];

    // Write one word on the rising edge when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Combinational reads for the core and for the peek port.
    always_comb begin
        rdata_a = cells[raddr_a];
        rdata_b = cells[raddr_b];
    end
endmodule

// File: rtl/accum_seq.sv
`timescale 1ns/1ps
// Module accum_seq
// Phase sequencer. It holds the program counter and the instruction register, steps
// fetch/decode/execute and resolves branches and halt in the execute phase.
// Assumes rdata is memory at the fetch address while in the fetch phase.
module accum_seq
    import accum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero_flag,
    input  logic [WORD_W-1:0] rdata,
    output phase_e            phase,
    output logic [WORD_W-1:0] ir,
    output logic [ADDR_W-1:0] pc
);
    logic [OP_W-1:0]   ir_op;
    logic [ADDR_W-1:0] ir_addr;

    // Split the held instruction into its fields.
    always_comb begin
        ir_op   = ir[WORD_W-1 -: OP_W];
        ir_addr = ir[ADDR_W-1:0];
    end

    // Advance the phase, capture instructions and update the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_FETCH;
            ir    <= '0;
            pc    <= '0;
        end else begin
            case (phase)
                PH_FETCH: begin
                    ir    <= rdata;
                    pc    <= pc + ADDR_W'(1);
                    phase <= PH_DECODE;
                end
                PH_DECODE: begin
                    phase <= PH_EXEC;
                end
                PH_EXEC: begin
                    phase <= PH_FETCH;
                    case (ir_op)
                        OP_BR:   pc <= ir_addr;
                        OP_BRZ:  if (zero_flag) pc <= ir_addr;
                        OP_HALT: phase <= PH_HALT;
                        default: ;
                    endcase
                end
                default: begin
                    phase <= PH_HALT;
                end
            endcase
        end
    end
endmodule

// File: rtl/accum_dp.sv
`timescale 1ns/1ps
// Module accum_dp
// Datapath. It latches the operand in decode, then in execute updates the accumulator and
// the zero flag for load, add and subtract. Arithmetic wraps at the word width.
// Assumes rdata is memory at the instruction's address while in the decode phase.
module accum_dp
    import accum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] acc,
    output logic              zero_flag
);
    logic [WORD_W-1:0] opnd;
    logic [WORD_W-1:0] result;
    logic              writes_acc;

    // Select the execute-phase result and whether it reaches the accumulator.
    always_comb begin
        result     = acc;
        writes_acc = 1'b0;
        case (op)
            OP_LOAD: begin result = opnd;        writes_acc = 1'b1; end
            OP_ADD:  begin result = acc + opnd;  writes_acc = 1'b1; end
            OP_SUB:  begin result = acc - opnd;  writes_acc = 1'b1; end
            default: ;
        endcase
    end

    // Latch the operand, then commit the accumulator and flag in execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd      <= '0;
            acc       <= '0;
            zero_flag <= 1'b0;
        end else begin
            if (phase == PH_DECODE) begin
                opnd <= rdata;
            end
            if (phase == PH_EXEC && writes_acc) begin
                acc       <= result;
                zero_flag <= (result == '0);
            end
        end
    end
endmodule

// File: rtl/accum_core.sv
`timescale 1ns/1ps
// Module accum_core
// Top of the one-address accumulator processor: sequencer, datapath and shared memory.
// Assumes memory is preloaded through the load port while rst_n is low; the memory
// itself has no reset. MEM_WORDS must be a power of two no larger than 4096.
module accum_core
    import accum_pkg::*;
#(
    parameter int MEM_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [11:0]       load_addr,
    input  logic [15:0]       load_data,
    input  logic [11:0]       peek_addr,
    output logic [15:0]       peek_data,
    output logic [15:0]       acc_out,
    output logic [11:0]       pc_out,
    output logic              halted
);
    localparam int IDX_W = $clog2(MEM_WORDS);

    phase_e            phase;
    logic [WORD_W-1:0] ir;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] acc;
    logic              zf;
    logic [WORD_W-1:0] core_rdata;
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] ir_addr;
    logic              core_we;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_waddr;
    logic [WORD_W-1:0] mem_wdata;
    logic [IDX_W-1:0]  core_raddr;

    // Decode fields and arbitrate memory between the core and the load port.
    always_comb begin
        op         = ir[WORD_W-1 -: OP_W];
        ir_addr    = ir[ADDR_W-1:0];
        core_we    = (phase == PH_EXEC) && (op == OP_STORE);
        mem_we     = core_we || (load_en && !rst_n);
        mem_waddr  = core_we ? ir_addr[IDX_W-1:0] : load_addr[IDX_W-1:0];
        mem_wdata  = core_we ? acc : load_data;
        core_raddr = (phase == PH_FETCH) ? pc[IDX_W-1:0] : ir_addr[IDX_W-1:0];
    end

    // Drive the observation outputs.
    always_comb begin
        acc_out = acc;
        pc_out  = pc;
        halted  = (phase == PH_HALT);
    end

    accum_mem #(.WORDS(MEM_WORDS), .DATA_W(WORD_W)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (core_raddr),
        .rdata_a (core_rdata),
        .raddr_b (peek_addr[IDX_W-1:0]),
        .rdata_b (peek_data)
    );

    accum_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_flag (zf),
        .rdata     (core_rdata),
        .phase     (phase),
        .ir        (ir),
        .pc        (pc)
    );

    accum_dp u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .op        (op),
        .rdata     (core_rdata),
        .acc       (acc),
        .zero_flag (zf)
    );
endmodule

// File: rtl/accum_core_chk.sv
`timescale 1ns/1ps
// Module accum_core_chk
// Property checker for accum_core, attached by bind. It observes the phase, the
// instruction register, the program counter, the accumulator and the zero flag.
module accum_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  phase,
    input logic [15:0] ir,
    input logic [11:0] pc,
    input logic [15:0] acc,
    input logic        zf,
    input logic [15:0] rdata,
    input logic        halted
);
    logic [3:0] op;
    logic       in_exec;

    // Name the fields that the properties use.
    always_comb begin
        op      = ir[15:12];
        in_exec = (phase == 2'd2);
    end

    p_fetch_to_decode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |=> (phase == 2'd1));

    p_decode_to_exec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |=> (phase == 2'd2));

    p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(acc)));

    p_flag_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && (op == 4'b0011 || op == 4'b0101 || op == 4'b0110)) |=> $stable(zf));

    p_add_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && op == 4'b0001) |=> (acc == 16'($past(acc) + $past(rdata, 2))));

    p_br_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && op == 4'b0110) |=> (pc == $past(ir[11:0])));

    p_noop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && !(op inside {4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b1111}))
        |=> ($stable(acc) && $stable(zf) && $stable(pc)));
endmodule

bind accum_core accum_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .ir     (ir),
    .pc     (pc),
    .acc    (acc),
    .zf     (zf),
    .rdata  (core_rdata),
    .halted (halted)
);

// File: tb/sim_accum_core.sv
`timescale 1ns/1ps
// Bench sim_accum_core: directed scenarios, one task each. Inputs change and outputs
// are sampled on falling clock edges.
module sim_accum_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [11:0] load_addr = '0;
    logic [15:0] load_data = '0;
    logic [11:0] peek_addr = '0;
    logic [15:0] peek_data;
    logic [15:0] acc_out;
    logic [11:0] pc_out;
    logic        halted;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [3:0] ADD = 4'b0001, LDA = 4'b0010, STA = 4'b0011, SUB = 4'b0100;
    localparam logic [3:0] BRZ = 4'b0101, BRA = 4'b0110, HLT = 4'b1111;

    always #2 clk = ~clk;

    accum_core u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
        .acc_out(acc_out), .pc_out(pc_out), .halted(halted)
    );

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        load_en = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [15:0] d);
        peek_addr = a;
        #0.5;
        d = peek_data;
    endtask

    // Releases reset on a falling edge and counts edges until halted (or limit).
    task automatic run(input int limit, output int cycles);
        rst_n = 1'b1;
        cycles = 0;
        while (!halted && cycles < limit) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        hold_reset();
        poke(12'h000, ins(HLT, 12'h000));
        check("R2 acc in reset", acc_out, 16'h0000);
        check("R2 pc in reset", {4'h0, pc_out}, 16'h0000);
        check("R2 halted in reset", {15'h0, halted}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 pc after fetch", {4'h0, pc_out}, 16'h0001);
        @(negedge clk);
        check("R12 not halted at edge 2", {15'h0, halted}, 16'h0000);
        @(negedge clk);
        check("R10 halted at edge 3", {15'h0, halted}, 16'h0001);
        peek(12'h000, d);
        check("R1 halt word kept", d, 16'hF000);
    endtask

    task automatic t_sum();
        int cyc;
        logic [15:0] d;
        hold_reset();
        poke(12'h000, ins(LDA, 12'h201));
        poke(12'h001, ins(ADD, 12'h202));
        poke(12'h002, ins(ADD, 12'h203));
        poke(12'h003, ins(STA, 12'h204));
        poke(12'h004, ins(HLT, 12'h000));
        poke(12'h201, 16'd2); poke(12'h202, 16'd3); poke(12'h203, 16'd4); poke(12'h204, 16'd0);
        run(100, cyc);
        check("R12 sum program cycles", 16'(cyc), 16'd15);
        peek(12'h204, d);
        check("R6 sum stored", d, 16'd9);
        check("R3 R4 sum in acc", acc_out, 16'd9);
    endtask

    task automatic t_wrap();
        int cyc;
        logic [15:0] d;
        hold_reset();
        poke(12'h000, ins(LDA, 12'h150));
        poke(12'h001, ins(ADD, 12'h151));
        poke(12'h002, ins(STA, 12'h152));
        poke(12'h003, ins(SUB, 12'h153));
        poke(12'h004, ins(STA, 12'h154));
        poke(12'h005, ins(HLT, 12'h000));
        poke(12'h150, 16'hFFFF); poke(12'h151, 16'h0003); poke(12'h153, 16'h0005);
        run(100, cyc);
        peek(12'h152, d);
        check("R4 add wraps", d, 16'h0002);
        peek(12'h154, d);
        check("R5 sub wraps", d, 16'hFFFD);
    endtask

    task automatic t_brz_taken();
        int cyc;
        logic [15:0] d;
        hold_reset();
        poke(12'h000, ins(LDA, 12'h100));
        poke(12'h001, ins(SUB, 12'h101));
        poke(12'h002, ins(STA, 12'h110));
        poke(12'h003, ins(BRZ, 12'h005));
        poke(12'h004, ins(HLT, 12'h000));
        poke(12'h005, ins(LDA, 12'h102));
        poke(12'h006, ins(STA, 12'h111));
        poke(12'h007, ins(HLT, 12'h000));
        poke(12'h100, 16'd5); poke(12'h101, 16'd5); poke(12'h102, 16'd7);
        poke(12'h110, 16'h1111); poke(12'h111, 16'hDEAD);
        run(100, cyc);
        peek(12'h110, d);
        check("R5 zero difference stored", d, 16'h0000);
        peek(12'h111, d);
        check("R7 R8 branch taken after store", d, 16'd7);
        check("R12 taken path cycles", 16'(cyc), 16'd21);
    endtask

    task automatic t_brz_fall();
        int cyc;
        logic [15:0] d;
        hold_reset();
        poke(12'h000, ins(LDA, 12'h100));
        poke(12'h001, ins(SUB, 12'h102));
        poke(12'h002, ins(BRZ, 12'h005));
        poke(12'h003, ins(STA, 12'h112));
        poke(12'h004, ins(HLT, 12'h000));
        poke(12'h005, ins(LDA, 12'h101));
        poke(12'h006, ins(STA, 12'h113));
        poke(12'h007, ins(HLT, 12'h000));
        poke(12'h112, 16'h0000); poke(12'h113, 16'hBEEF);
        run(100, cyc);
        peek(12'h112, d);
        check("R8 fallthrough stores", d, 16'hFFFE);
        peek(12'h113, d);
        check("R8 target not reached", d, 16'hBEEF);
    endtask

    task automatic t_load_zero();
        int cyc;
        logic [15:0] d;
        hold_reset();
        poke(12'h000, ins(LDA, 12'h140));
        poke(12'h001, ins(BRZ, 12'h003));
        poke(12'h002, ins(HLT, 12'h000));
        poke(12'h003, ins(LDA, 12'h141));
        poke(12'h004, ins(STA, 12'h142));
        poke(12'h005, ins(HLT, 12'h000));
        poke(12'h140, 16'h0000); poke(12'h141, 16'd9); poke(12'h142, 16'h0000);
        run(100, cyc);
        peek(12'h142, d);
        check("R7 load of zero sets flag", d, 16'd9);
    endtask

    task automatic t_loop();
        int cyc;
        logic [15:0] d;
        hold_reset();
        poke(12'h000, ins(LDA, 12'h122));
        poke(12'h001, ins(ADD, 12'h123));
        poke(12'h002, ins(STA, 12'h122));
        poke(12'h003, ins(LDA, 12'h120));
        poke(12'h004, ins(SUB, 12'h121));
        poke(12'h005, ins(STA, 12'h120));
        poke(12'h006, ins(BRZ, 12'h008));
        poke(12'h007, ins(BRA, 12'h000));
        poke(12'h008, ins(HLT, 12'h000));
        poke(12'h120, 16'd3); poke(12'h121, 16'd1); poke(12'h122, 16'd0); poke(12'h123, 16'd2);
        run(500, cyc);
        peek(12'h122, d);
        check("R9 backward loop sum", d, 16'd6);
        peek(12'h120, d);
        check("R9 loop counter", d, 16'd0);
        check("R12 loop cycles", 16'(cyc), 16'd72);
    endtask

    task automatic t_noop_fwd();
        int cyc;
        logic [15:0] d;
        hold_reset();
        poke(12'h000, ins(LDA, 12'h130));
        poke(12'h001, ins(4'b0000, 12'h130));
        poke(12'h002, ins(4'b1110, 12'h130));
        poke(12'h003, ins(BRA, 12'h005));
        poke(12'h004, ins(STA, 12'h131));
        poke(12'h005, ins(ADD, 12'h132));
        poke(12'h006, ins(STA, 12'h133));
        poke(12'h007, ins(HLT, 12'h000));
        poke(12'h130, 16'h0042); poke(12'h131, 16'h5555); poke(12'h132, 16'd1);
        run(100, cyc);
        peek(12'h131, d);
        check("R9 forward branch skips", d, 16'h5555);
        peek(12'h133, d);
        check("R11 no-ops keep acc", d, 16'h0043);
        peek(12'h130, d);
        check("R11 no-op leaves memory", d, 16'h0042);
        check("R12 no-op path cycles", 16'(cyc), 16'd21);
    endtask

    task automatic t_halt_hold();
        int cyc;
        logic [15:0] d;
        hold_reset();
        poke(12'h000, ins(LDA, 12'h160));
        poke(12'h001, ins(HLT, 12'h000));
        poke(12'h002, ins(STA, 12'h161));
        poke(12'h160, 16'h1234); poke(12'h161, 16'h7777);
        run(100, cyc);
        check("R12 halt program cycles", 16'(cyc), 16'd6);
        repeat (20) @(negedge clk);
        check("R10 still halted", {15'h0, halted}, 16'h0001);
        check("R10 pc frozen", {4'h0, pc_out}, 16'h0002);
        check("R10 acc frozen", acc_out, 16'h1234);
        peek(12'h161, d);
        check("R10 no fetch after halt", d, 16'h7777);
        poke(12'h161, 16'hAAAA);
        peek(12'h161, d);
        check("R13 load ignored out of reset", d, 16'h7777);
        hold_reset();
        check("R10 reset clears halted", {15'h0, halted}, 16'h0000);
        poke(12'h161, 16'hAAAA);
        peek(12'h161, d);
        check("R13 load taken in reset", d, 16'hAAAA);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sum();
        t_wrap();
        t_brz_taken();
        t_brz_fall();
        t_load_zero();
        t_loop();
        t_noop_fwd();
        t_halt_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule